// File: doc/BRIEF.md
# Successive-Approximation Converter Sequencer

This block is the digital half of an 8-bit successive-approximation analog-to-digital converter with eight inputs. A one-cycle `start` strobe, with a channel number and two clock settings beside it, launches a conversion. The block turns the system clock into a slower conversion clock. It holds the input in a fixed sampling window and then runs a binary search, most significant bit first. Each trial code goes out on `dac_code` to an external DAC. The external comparator returns `cmp_hi`, and the block decides each bit from it.

The conversion-clock period is a base divider times an optional halving. The `clk_ctl` field selects a base of 2, 4 or 16 system clocks. The `fadc_full` bit keeps that base (1) or doubles it (0). A conversion always spans 160 conversion-clock periods. The first 12 periods are sampling. Each of the eight bit decisions takes 18 periods. The last 4 periods hold the finished code. The result is then posted with a done flag.

Top module: `adc_sar_sequencer`

## Requirements
- R1: One conversion-clock period lasts B×M system clocks. B is 2 for `clk_ctl`=00, 4 for 01, 16 for 11, and 2 for the reserved value 10. M is 1 when `fadc_full`=1 and 2 when `fadc_full`=0. The settings are captured at the clock edge that accepts `start`.
- R2: `busy` rises at the accepting edge and falls exactly 160×B×M system-clock edges later. `busy` and `done` are never high together.
- R3: During periods 0 to 11 of a conversion, `sampling` is 1 and `dac_code` is 0. Outside those periods `sampling` is 0.
- R4: Bit k (k=0 is the MSB) occupies periods 12+18k to 29+18k. During that window `dac_code` equals the bits already decided, with bit 7−k set to 1.
- R5: A trial bit is kept when `cmp_hi` is 1 (input at or above the trial level) and cleared otherwise. `cmp_hi` is sampled on the last system clock of the bit's final period. With an ideal comparator, the result equals the input level.
- R6: During periods 156 to 159 `dac_code` shows the finished code. Between conversions it keeps the last finished code, or 0 after reset.
- R7: A `start` while `busy` is high is ignored. The channel, settings, timing and result of the running conversion are unaffected.
- R8: `done` goes to 1 at the edge where `busy` falls. It holds until the edge that accepts the next `start`, where it clears.
- R9: `result` is updated only at the edge where `done` sets, and holds otherwise.
- R10: `mux_sel` takes `chan_sel` at the accepting edge and stays constant until the next accepted start.
- R11: After reset, `busy`, `done`, `sampling`, `result`, `dac_code` and `mux_sel` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Conversion request strobe |
| chan_sel | input | 3 | Input channel for the requested conversion |
| clk_ctl | input | 2 | Base divider code (00: /2, 01: /4, 11: /16, 10: /2) |
| fadc_full | input | 1 | 1: conversion clock equals the base clock; 0: half of it |
| cmp_hi | input | 1 | Comparator: input at or above `dac_code` |
| mux_sel | output | 3 | Channel applied to the analog multiplexer |
| dac_code | output | 8 | Trial code sent to the DAC |
| sampling | output | 1 | Sampling window active |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | Conversion finished, result valid |
| result | output | 8 | Last finished conversion code |

## Verification
`done` and `result` are due exactly 160×B×M edges after the edge that accepts `start`. Each trial code changes on the edge that ends the previous bit's last period, 18×B×M edges apart. The reference model counts edges since acceptance and derives the expected phase, trial code and flags from that count and the sampled input level. Every output is compared at the falling clock edge, half a cycle after the rising edge that moved it. Each conversion also measures the falling-edge count from the start strobe to `done`, checks it against 160×B×M+1, and checks `result` against the channel's level.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int unsigned RES_W      = 8;
    localparam int unsigned CH_W       = 3;
    localparam int unsigned TOTAL_PER  = 160;
    localparam int unsigned SAMPLE_PER = 12;
    localparam int unsigned RATIO_W    = 6;

    typedef enum logic [1:0] {
        BASE_DIV2  = 2'b00,
        BASE_DIV4  = 2'b01,
        BASE_RSV   = 2'b10,
        BASE_DIV16 = 2'b11
    } base_sel_e;

    // system clocks per conversion-clock period
    function automatic logic [RATIO_W-1:0] fadc_ratio(input logic [1:0] sel,
                                                      input logic full);
        logic [RATIO_W-1:0] base;
        case (base_sel_e'(sel))
            BASE_DIV4:  base = RATIO_W'(4);
            BASE_DIV16: base = RATIO_W'(16);
            default:    base = RATIO_W'(2);
        endcase
        return full ? base : (base << 1);
    endfunction

endpackage

// File: rtl/adc_seq_prescaler.sv
module adc_seq_prescaler #(
    parameter int unsigned RATIO_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               restart,
    input  logic               run,
    input  logic [RATIO_W-1:0] ratio,
    output logic               tick
);

    typedef struct packed {
        logic [RATIO_W-1:0] cnt;
    } pre_t;

    pre_t st_d, st_q;

    assign tick = run && (st_q.cnt == (ratio - RATIO_W'(1)));

    always_comb begin
        st_d = st_q;
        if (restart) begin
            st_d.cnt = '0;
        end else if (run) begin
            st_d.cnt = tick ? '0 : st_q.cnt + RATIO_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/adc_seq_timer.sv
module adc_seq_timer #(
    parameter int unsigned RES_W      = 8,
    parameter int unsigned TOTAL_PER  = 160,
    parameter int unsigned SAMPLE_PER = 12
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      restart,
    input  logic                      run,
    input  logic                      tick,
    output logic                      sampling,
    output logic                      searching,
    output logic [$clog2(RES_W)-1:0]  bit_idx,
    output logic                      decide,
    output logic                      last
);

    localparam int unsigned BIT_PER    = (TOTAL_PER - SAMPLE_PER) / RES_W;
    localparam int unsigned SEARCH_END = SAMPLE_PER + BIT_PER * RES_W;
    localparam int unsigned PER_W      = $clog2(TOTAL_PER);
    localparam int unsigned SEG_W      = $clog2(BIT_PER);
    localparam int unsigned BIDX_W     = $clog2(RES_W);

    localparam logic [PER_W-1:0] SAMP_L = PER_W'(SAMPLE_PER);
    localparam logic [PER_W-1:0] SEND_L = PER_W'(SEARCH_END);
    localparam logic [PER_W-1:0] LAST_L = PER_W'(TOTAL_PER - 1);
    localparam logic [SEG_W-1:0] SEGL_L = SEG_W'(BIT_PER - 1);

    typedef struct packed {
        logic [PER_W-1:0]  per;
        logic [SEG_W-1:0]  seg;
        logic [BIDX_W-1:0] bidx;
    } tim_t;

    tim_t st_d, st_q;

    assign sampling  = run && (st_q.per < SAMP_L);
    assign searching = run && (st_q.per >= SAMP_L) && (st_q.per < SEND_L);
    assign bit_idx   = st_q.bidx;
    assign decide    = tick && searching && (st_q.seg == SEGL_L);
    assign last      = tick && (st_q.per == LAST_L);

    always_comb begin
        st_d = st_q;
        if (restart) begin
            st_d = '0;
        end else if (tick) begin
            st_d.per = last ? '0 : st_q.per + PER_W'(1);
            if (searching) begin
                st_d.seg  = decide ? '0 : st_q.seg + SEG_W'(1);
                st_d.bidx = decide ? st_q.bidx + BIDX_W'(1) : st_q.bidx;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/adc_seq_sar.sv
module adc_seq_sar #(
    parameter int unsigned RES_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clear,
    input  logic                     searching,
    input  logic                     decide,
    input  logic [$clog2(RES_W)-1:0] bit_idx,
    input  logic                     cmp_hi,
    output logic [RES_W-1:0]         code,
    output logic [RES_W-1:0]         dac_code
);

    localparam int unsigned BIDX_W = $clog2(RES_W);

    logic [RES_W-1:0] code_d, code_q, trial;

    for (genvar i = 0; i < RES_W; i++) begin : g_bit
        assign trial[i] = searching && (bit_idx == BIDX_W'(RES_W - 1 - i));
        assign code_d[i] = clear ? 1'b0 :
                           (decide && trial[i]) ? cmp_hi : code_q[i];
    end

    assign code     = code_q;
    assign dac_code = code_q | trial;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) code_q <= '0;
        else        code_q <= code_d;
    end

endmodule

// File: rtl/adc_sar_sequencer.sv
module adc_sar_sequencer
    import adc_seq_pkg::*;
#(
    parameter int unsigned P_RES_W      = RES_W,
    parameter int unsigned P_CH_W       = CH_W,
    parameter int unsigned P_TOTAL_PER  = TOTAL_PER,
    parameter int unsigned P_SAMPLE_PER = SAMPLE_PER
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [P_CH_W-1:0]  chan_sel,
    input  logic [1:0]         clk_ctl,
    input  logic               fadc_full,
    input  logic               cmp_hi,
    output logic [P_CH_W-1:0]  mux_sel,
    output logic [P_RES_W-1:0] dac_code,
    output logic               sampling,
    output logic               busy,
    output logic               done,
    output logic [P_RES_W-1:0] result
);

    localparam int unsigned BIDX_W = $clog2(P_RES_W);

    typedef struct packed {
        logic               busy;
        logic               done;
        logic [P_RES_W-1:0] result;
        logic [P_CH_W-1:0]  chan;
        logic [RATIO_W-1:0] ratio;
    } ctl_t;

    ctl_t st_d, st_q;

    logic              accept, tick, searching, decide, last;
    logic [BIDX_W-1:0] bit_idx;
    logic [P_RES_W-1:0] code;

    assign accept = start && !st_q.busy;

    adc_seq_prescaler #(.RATIO_W(RATIO_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (accept),
        .run     (st_q.busy),
        .ratio   (st_q.ratio),
        .tick    (tick)
    );

    adc_seq_timer #(
        .RES_W      (P_RES_W),
        .TOTAL_PER  (P_TOTAL_PER),
        .SAMPLE_PER (P_SAMPLE_PER)
    ) u_tim (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (accept),
        .run       (st_q.busy),
        .tick      (tick),
        .sampling  (sampling),
        .searching (searching),
        .bit_idx   (bit_idx),
        .decide    (decide),
        .last      (last)
    );

    adc_seq_sar #(.RES_W(P_RES_W)) u_sar (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (accept),
        .searching (searching),
        .decide    (decide),
        .bit_idx   (bit_idx),
        .cmp_hi    (cmp_hi),
        .code      (code),
        .dac_code  (dac_code)
    );

    always_comb begin
        st_d = st_q;
        if (accept) begin
            st_d.busy  = 1'b1;
            st_d.done  = 1'b0;
            st_d.chan  = chan_sel;
            st_d.ratio = fadc_ratio(clk_ctl, fadc_full);
        end else if (last) begin
            st_d.busy   = 1'b0;
            st_d.done   = 1'b1;
            st_d.result = code;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.ratio <= RATIO_W'(2);
        end else begin
            st_q <= st_d;
        end
    end

    assign mux_sel = st_q.chan;
    assign busy    = st_q.busy;
    assign done    = st_q.done;
    assign result  = st_q.result;

endmodule

// File: rtl/adc_sar_sequencer_chk.sv
module adc_sar_sequencer_chk #(
    parameter int unsigned RW = 8,
    parameter int unsigned CW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic          sampling,
    input logic [RW-1:0] dac_code,
    input logic [RW-1:0] result,
    input logic [CW-1:0] mux_sel
);

    p_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && !done));

    p_fall_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    p_done_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    p_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    p_samp_dac_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sampling |-> (dac_code == '0 && busy));

    p_mux_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(mux_sel));

    p_idle_result_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(result));

    p_busy_result_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (!busy || $stable(result)));

endmodule

bind adc_sar_sequencer adc_sar_sequencer_chk #(.RW(P_RES_W), .CW(P_CH_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .sampling (sampling),
    .dac_code (dac_code),
    .result   (result),
    .mux_sel  (mux_sel)
);

// File: tb/adc_sar_sequencer_test.sv
`timescale 1ns/1ps
module adc_sar_sequencer_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [2:0] chan_sel = '0;
    logic [1:0] clk_ctl = '0;
    logic       fadc_full = 1'b0;
    logic       cmp_hi;
    logic [2:0] mux_sel;
    logic [7:0] dac_code, result;
    logic       sampling, busy, done;

    logic [7:0] ain [8];
    initial begin
        ain[0] = 8'h3C; ain[1] = 8'h00; ain[2] = 8'h7F; ain[3] = 8'hA5;
        ain[4] = 8'h11; ain[5] = 8'h80; ain[6] = 8'hC3; ain[7] = 8'hFF;
    end

    // ideal comparator on the selected channel
    assign cmp_hi = (ain[mux_sel] >= dac_code);

    always #2 clk = ~clk;

    adc_sar_sequencer uut (
        .clk(clk), .rst_n(rst_n), .start(start), .chan_sel(chan_sel),
        .clk_ctl(clk_ctl), .fadc_full(fadc_full), .cmp_hi(cmp_hi),
        .mux_sel(mux_sel), .dac_code(dac_code), .sampling(sampling),
        .busy(busy), .done(done), .result(result)
    );

    int n_chk = 0;
    int n_bad = 0;
    int wd = 0;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic int ratio_of(input int ctl, input int full);
        int b;
        b = (ctl == 1) ? 4 : (ctl == 3) ? 16 : 2;
        return full ? b : 2 * b;
    endfunction

    // behavioural reference: edge count since acceptance
    int m_busy = 0, m_done = 0, m_result = 0, m_n = 0, m_ratio = 2;
    int m_vin = 0, m_chan = 0, m_hold = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_result = 0; m_n = 0; m_chan = 0; m_hold = 0;
        end else if (m_busy != 0) begin
            m_n++;
            if (m_n == 160 * m_ratio) begin
                m_busy = 0; m_done = 1; m_result = m_vin; m_hold = m_vin;
            end
        end else if (start) begin
            m_busy = 1; m_done = 0; m_n = 0; m_hold = 0;
            m_chan = int'(chan_sel);
            m_ratio = ratio_of(int'(clk_ctl), int'(fadc_full));
            m_vin = int'(ain[chan_sel]);
        end
    end

    always @(posedge clk) begin
        wd++;
        if (wd > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL R2 watchdog expired actual=%0d expected=%0d", wd, 150000);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            int p, b, e_dac, e_samp;
            string tg;
            e_samp = 0;
            if (m_busy != 0) begin
                p = m_n / m_ratio;
                if (p < 12) begin
                    e_dac = 0; e_samp = 1; tg = "R3";
                end else if (p < 156) begin
                    b = (p - 12) / 18;
                    e_dac = (m_vin & ((255 << (8 - b)) & 255)) | (128 >> b);
                    tg = "R4";
                end else begin
                    e_dac = m_vin; tg = "R6";
                end
            end else begin
                e_dac = m_hold; tg = "R6";
            end
            chk("R2 busy", int'(busy), m_busy);
            chk("R8 done", int'(done), m_done);
            chk("R9 result", int'(result), m_result);
            chk({tg, " dac_code"}, int'(dac_code), e_dac);
            chk("R3 sampling", int'(sampling), e_samp);
            chk("R10 mux_sel", int'(mux_sel), m_chan);
        end
    end

    task automatic run_conv(input int ch, input int ctl, input int full, input int intrude);
        int cyc, r;
        r = ratio_of(ctl, full);
        @(negedge clk);
        start = 1'b1; chan_sel = 3'(ch); clk_ctl = 2'(ctl); fadc_full = full[0];
        @(negedge clk);
        start = 1'b0; cyc = 1;
        chk("R8 done cleared at accept", int'(done), 0);
        while (!done && cyc < 6000) begin
            @(negedge clk);
            cyc++;
            if (cyc == intrude) begin
                start = 1'b1; chan_sel = 3'd6; clk_ctl = 2'd3; fadc_full = 1'b0;
            end else begin
                start = 1'b0;
            end
        end
        start = 1'b0;
        if (intrude != 0) begin
            chk("R7 timing after ignored start", cyc, 160 * r + 1);
            chk("R7 result after ignored start", int'(result), int'(ain[ch]));
        end else begin
            chk("R1 conversion length", cyc, 160 * r + 1);
            chk("R5 result equals input", int'(result), int'(ain[ch]));
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R11 busy", int'(busy), 0);
        chk("R11 done", int'(done), 0);
        chk("R11 result", int'(result), 0);
        chk("R11 dac_code", int'(dac_code), 0);
        chk("R11 sampling", int'(sampling), 0);
        chk("R11 mux_sel", int'(mux_sel), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        run_conv(3, 0, 1, 0);   // ratio 2
        run_conv(1, 1, 0, 0);   // ratio 8
        run_conv(7, 3, 1, 0);   // ratio 16
        run_conv(5, 2, 1, 0);   // reserved code, ratio 2
        run_conv(2, 3, 0, 0);   // ratio 32
        run_conv(4, 0, 0, 0);   // ratio 4, right after previous
        repeat (5) @(negedge clk);
        chk("R9 result held while idle", int'(result), int'(ain[4]));
        chk("R8 done held while idle", int'(done), 1);
        run_conv(0, 1, 1, 300); // start during conversion is ignored
        run_conv(6, 1, 1, 0);
        repeat (4) @(negedge clk);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule